// File: doc/BRIEF.md
# Integer ALU with Shifter and Compare

This block is the 32-bit integer execute unit of a small core. For each operation it takes two source register values, their register indices, a 16-bit immediate, a 5-bit shift count and a destination index. It returns a 32-bit result and a write strobe for the register file.

The unit covers the following operations:
- add, subtract and multiply (low word);
- the bitwise operations;
- immediate forms, including ones that act on the upper half-word;
- six set-on-compare conditions, each with a register form and an immediate form;
- logical and arithmetic shifts and rotates, with the amount taken either from a register or from an immediate;
- three signedness variants of multiply-high.

The core sends operations through a valid/ready stream and takes results out through a second valid/ready stream. An operation is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. When `REG_OUT` is set (the default), results pass through a single register slice:
- the result shows on the output one cycle after acceptance;
- it stays there, unchanged, until `out_ready` is seen high;
- `in_ready` is high whenever the slice is empty or is being drained in the same cycle.

When `REG_OUT` is clear, the block is purely combinational: `in_ready` follows `out_ready` and `out_valid` follows `in_valid`.

Top module: `int_alu`

## Requirements
- R1: The register forms add, subtract, multiply-low, and, or, xor and nor return the 32-bit result wrapped modulo 2^32. Multiply-low returns bits 31:0 of the product.
- R2: The add-immediate and multiply-immediate forms sign-extend the 16-bit immediate before operating.
- R3: The and-, or- and xor-immediate forms zero-extend the 16-bit immediate.
- R4: The upper-half forms of and-, or- and xor-immediate use the immediate in bits 31:16 with zeros in bits 15:0. Upper-half and therefore clears bits 15:0 of the result.
- R5: The register compares (signed >=, signed <, !=, ==, unsigned >=, unsigned <) return exactly 1 or 0.
- R6: The immediate compares sign-extend the immediate for signed >=, signed <, != and ==, and zero-extend it for unsigned >= and unsigned <.
- R7: The register shifts and rotates (arithmetic right, logical right, left, rotate left, rotate right) use only bits 4:0 of the B operand as the amount.
- R8: The immediate shifts (arithmetic right, logical right, left) and rotate-left-immediate take the amount from `shamt`. An amount of 0 returns A unchanged.
- R9: The multiply-high forms return bits 63:32 of the 64-bit product for signed×signed, unsigned×unsigned and signed A × unsigned B.
- R10: A source whose index is 0 reads as zero, whatever value is on its operand port.
- R11: `wr_en` is low when `dest` is 0 or the operation code is undefined. Codes 39 to 63 are undefined, and an undefined code returns a result of 0. Otherwise `wr_en` is high and `wr_dest` equals `dest`.
- R12: With `REG_OUT` set, an accepted operation appears with `out_valid` on the next cycle. While `out_valid` is high and `out_ready` is low, `out_valid`, `result`, `wr_en` and `wr_dest` hold. `in_ready` is high whenever `out_valid` is low or `out_ready` is high.
- R13: While `rst_n` is low, and after it is released until the first accepted operation, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken |
| op | input | 6 | Operation code (0 to 38 defined) |
| src_a | input | 5 | Register index of operand A |
| opa | input | 32 | Operand A value |
| src_b | input | 5 | Register index of operand B |
| opb | input | 32 | Operand B value |
| imm | input | 16 | Immediate field |
| shamt | input | 5 | Immediate shift amount |
| dest | input | 5 | Destination register index |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes result |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Register-file write strobe |
| wr_dest | output | 5 | Destination register index |

## Verification
Hand-picked operands probe the value boundaries:
- all-ones, the most negative word and a high immediate bit separate sign extension from zero extension, and signed compares from unsigned ones;
- B values with high bits set but a small low field show whether the register shifts mask the amount;
- amounts of 0 and 31 test the rotate wrap-around;
- -1×-1, all-ones squared and the most negative word squared tell the three multiply-high signedness forms apart.

Random operations with random operands and source indices, some of them 0, run both with an always-ready consumer and with a consumer that stalls two cycles out of three. This mix exposes zero-forcing, lost or duplicated results, and payload changes under back-pressure.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int OP_W = 6;

  typedef enum logic [OP_W-1:0] {
    OP_ADD, OP_SUB, OP_MUL, OP_AND, OP_OR, OP_XOR, OP_NOR,
    OP_ADDI, OP_MULI, OP_ANDI, OP_ORI, OP_XORI, OP_ANDHI, OP_ORHI, OP_XORHI,
    OP_CGE, OP_CLT, OP_CNE, OP_CEQ, OP_CGEU, OP_CLTU,
    OP_CGEI, OP_CLTI, OP_CNEI, OP_CEQI, OP_CGEUI, OP_CLTUI,
    OP_SRA, OP_SRL, OP_SLL, OP_ROL, OP_ROR,
    OP_SRAI, OP_SRLI, OP_SLLI, OP_ROLI,
    OP_MULHSS, OP_MULHUU, OP_MULHSU
  } alu_op_e;

  typedef enum logic [1:0] {IMM_NONE, IMM_SEXT, IMM_ZEXT, IMM_HIGH} imm_kind_e;
  typedef enum logic [2:0] {SH_SLL, SH_SRL, SH_SRA, SH_ROL, SH_ROR} shift_mode_e;
  typedef enum logic [2:0] {CC_GE, CC_LT, CC_NE, CC_EQ, CC_GEU, CC_LTU} cmp_cond_e;
  typedef enum logic [3:0] {
    RC_NONE, RC_ADD, RC_SUB, RC_MULLO, RC_MULHI,
    RC_AND, RC_OR, RC_XOR, RC_NOR, RC_CMP, RC_SHIFT
  } res_class_e;

  function automatic logic op_is_cmp(logic [OP_W-1:0] code);
    return (code >= OP_W'(OP_CGE)) && (code <= OP_W'(OP_CLTUI));
  endfunction

endpackage

// File: rtl/alu_opnd.sv
module alu_opnd
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int IDX_W  = 5
) (
  input  logic [IDX_W-1:0]  src_a,
  input  logic [DATA_W-1:0] opa,
  input  logic [IDX_W-1:0]  src_b,
  input  logic [DATA_W-1:0] opb,
  input  logic [IMM_W-1:0]  imm,
  input  imm_kind_e         kind,
  output logic [DATA_W-1:0] a_val,
  output logic [DATA_W-1:0] b_val
);
  localparam int PAD_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] b_reg;

  // index 0 is the hard-wired zero register
  assign a_val = (src_a == '0) ? '0 : opa;
  assign b_reg = (src_b == '0) ? '0 : opb;

  always_comb begin
    unique case (kind)
      IMM_SEXT: b_val = {{PAD_W{imm[IMM_W-1]}}, imm};
      IMM_ZEXT: b_val = {{PAD_W{1'b0}}, imm};
      IMM_HIGH: b_val = {imm, {PAD_W{1'b0}}};
      default:  b_val = b_reg;
    endcase
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SH_W   = 5
) (
  input  logic [DATA_W-1:0] din,
  input  logic [SH_W-1:0]   amt,
  input  shift_mode_e       mode,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] left, right, arith;

  assign left  = din << amt;
  assign right = din >> amt;
  assign arith = DATA_W'($signed(din) >>> amt);

  always_comb begin
    unique case (mode)
      SH_SRL:  dout = right;
      SH_SRA:  dout = arith;
      // an amount of 0 moves the complement part fully out (shift by width)
      SH_ROL:  dout = left | (din >> (DATA_W - int'(amt)));
      SH_ROR:  dout = right | (din << (DATA_W - int'(amt)));
      default: dout = left;
    endcase
  end
endmodule

// File: rtl/alu_mul.sv
module alu_mul #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b,
  input  logic                a_signed,
  input  logic                b_signed,
  output logic [2*DATA_W-1:0] prod
);
  localparam int PW = 2 * DATA_W;

  logic signed [DATA_W:0] ax, bx;
  logic signed [PW-1:0]   p;

  // one extra bit carries the chosen signedness into a single signed multiplier
  assign ax   = {a_signed & a[DATA_W-1], a};
  assign bx   = {b_signed & b[DATA_W-1], b};
  assign p    = PW'(ax) * PW'(bx);
  assign prod = p;
endmodule

// File: rtl/alu_cmp.sv
module alu_cmp
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  cmp_cond_e         cond,
  output logic              hit
);
  logic lt_s, lt_u, eq;

  assign lt_s = $signed(a) < $signed(b);
  assign lt_u = a < b;
  assign eq   = a == b;

  always_comb begin
    unique case (cond)
      CC_GE:   hit = !lt_s;
      CC_LT:   hit = lt_s;
      CC_NE:   hit = !eq;
      CC_GEU:  hit = !lt_u;
      CC_LTU:  hit = lt_u;
      default: hit = eq;
    endcase
  end
endmodule

// File: rtl/int_alu.sv
module int_alu
  import alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 16,
  parameter int IDX_W   = 5,
  parameter bit REG_OUT = 1'b1,
  localparam int SH_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   op,
  input  logic [IDX_W-1:0]  src_a,
  input  logic [DATA_W-1:0] opa,
  input  logic [IDX_W-1:0]  src_b,
  input  logic [DATA_W-1:0] opb,
  input  logic [IMM_W-1:0]  imm,
  input  logic [SH_W-1:0]   shamt,
  input  logic [IDX_W-1:0]  dest,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] result,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_dest
);
  alu_op_e     op_e;
  res_class_e  rc;
  imm_kind_e   ik;
  shift_mode_e smode;
  cmp_cond_e   cond;
  logic        s_imm, a_sg, b_sg, legal;

  logic [DATA_W-1:0]   a_val, b_val, sh_out, c_res;
  logic [SH_W-1:0]     sh_amt;
  logic [2*DATA_W-1:0] prod;
  logic                hit, c_we;

  assign op_e = alu_op_e'(op);

  // ---------------- decode ----------------
  always_comb begin
    rc = RC_NONE; ik = IMM_NONE; smode = SH_SLL; s_imm = 1'b0;
    cond = CC_EQ; a_sg = 1'b0; b_sg = 1'b0; legal = 1'b1;
    unique case (op_e)
      OP_ADD:    rc = RC_ADD;
      OP_SUB:    rc = RC_SUB;
      OP_MUL:    rc = RC_MULLO;
      OP_AND:    rc = RC_AND;
      OP_OR:     rc = RC_OR;
      OP_XOR:    rc = RC_XOR;
      OP_NOR:    rc = RC_NOR;
      OP_ADDI:   begin rc = RC_ADD;   ik = IMM_SEXT; end
      OP_MULI:   begin rc = RC_MULLO; ik = IMM_SEXT; end
      OP_ANDI:   begin rc = RC_AND;   ik = IMM_ZEXT; end
      OP_ORI:    begin rc = RC_OR;    ik = IMM_ZEXT; end
      OP_XORI:   begin rc = RC_XOR;   ik = IMM_ZEXT; end
      OP_ANDHI:  begin rc = RC_AND;   ik = IMM_HIGH; end
      OP_ORHI:   begin rc = RC_OR;    ik = IMM_HIGH; end
      OP_XORHI:  begin rc = RC_XOR;   ik = IMM_HIGH; end
      OP_CGE:    begin rc = RC_CMP; cond = CC_GE;  end
      OP_CLT:    begin rc = RC_CMP; cond = CC_LT;  end
      OP_CNE:    begin rc = RC_CMP; cond = CC_NE;  end
      OP_CEQ:    begin rc = RC_CMP; cond = CC_EQ;  end
      OP_CGEU:   begin rc = RC_CMP; cond = CC_GEU; end
      OP_CLTU:   begin rc = RC_CMP; cond = CC_LTU; end
      OP_CGEI:   begin rc = RC_CMP; cond = CC_GE;  ik = IMM_SEXT; end
      OP_CLTI:   begin rc = RC_CMP; cond = CC_LT;  ik = IMM_SEXT; end
      OP_CNEI:   begin rc = RC_CMP; cond = CC_NE;  ik = IMM_SEXT; end
      OP_CEQI:   begin rc = RC_CMP; cond = CC_EQ;  ik = IMM_SEXT; end
      OP_CGEUI:  begin rc = RC_CMP; cond = CC_GEU; ik = IMM_ZEXT; end
      OP_CLTUI:  begin rc = RC_CMP; cond = CC_LTU; ik = IMM_ZEXT; end
      OP_SRA:    begin rc = RC_SHIFT; smode = SH_SRA; end
      OP_SRL:    begin rc = RC_SHIFT; smode = SH_SRL; end
      OP_SLL:    begin rc = RC_SHIFT; smode = SH_SLL; end
      OP_ROL:    begin rc = RC_SHIFT; smode = SH_ROL; end
      OP_ROR:    begin rc = RC_SHIFT; smode = SH_ROR; end
      OP_SRAI:   begin rc = RC_SHIFT; smode = SH_SRA; s_imm = 1'b1; end
      OP_SRLI:   begin rc = RC_SHIFT; smode = SH_SRL; s_imm = 1'b1; end
      OP_SLLI:   begin rc = RC_SHIFT; smode = SH_SLL; s_imm = 1'b1; end
      OP_ROLI:   begin rc = RC_SHIFT; smode = SH_ROL; s_imm = 1'b1; end
      OP_MULHSS: begin rc = RC_MULHI; a_sg = 1'b1; b_sg = 1'b1; end
      OP_MULHUU: begin rc = RC_MULHI; end
      OP_MULHSU: begin rc = RC_MULHI; a_sg = 1'b1; end
      default:   legal = 1'b0;
    endcase
  end

  // ---------------- datapath ----------------
  alu_opnd #(.DATA_W(DATA_W), .IMM_W(IMM_W), .IDX_W(IDX_W)) u_opnd (
    .src_a(src_a), .opa(opa), .src_b(src_b), .opb(opb),
    .imm(imm), .kind(ik), .a_val(a_val), .b_val(b_val)
  );

  // register forms see only the low amount bits of B
  assign sh_amt = s_imm ? shamt : b_val[SH_W-1:0];

  alu_shift #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shift (
    .din(a_val), .amt(sh_amt), .mode(smode), .dout(sh_out)
  );

  alu_mul #(.DATA_W(DATA_W)) u_mul (
    .a(a_val), .b(b_val), .a_signed(a_sg), .b_signed(b_sg), .prod(prod)
  );

  alu_cmp #(.DATA_W(DATA_W)) u_cmp (
    .a(a_val), .b(b_val), .cond(cond), .hit(hit)
  );

  always_comb begin
    unique case (rc)
      RC_ADD:   c_res = a_val + b_val;
      RC_SUB:   c_res = a_val - b_val;
      RC_MULLO: c_res = prod[DATA_W-1:0];
      RC_MULHI: c_res = prod[2*DATA_W-1:DATA_W];
      RC_AND:   c_res = a_val & b_val;
      RC_OR:    c_res = a_val | b_val;
      RC_XOR:   c_res = a_val ^ b_val;
      RC_NOR:   c_res = ~(a_val | b_val);
      RC_CMP:   c_res = {{(DATA_W-1){1'b0}}, hit};
      RC_SHIFT: c_res = sh_out;
      default:  c_res = '0;
    endcase
  end

  assign c_we = legal && (dest != '0);

  // ---------------- output stage ----------------
  generate
    if (REG_OUT) begin : g_slice
      logic              q_valid, q_we;
      logic [DATA_W-1:0] q_res;
      logic [IDX_W-1:0]  q_dst;

      assign in_ready = !q_valid || out_ready;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q_valid <= 1'b0;
          q_res   <= '0;
          q_we    <= 1'b0;
          q_dst   <= '0;
        end else if (in_ready) begin
          q_valid <= in_valid;
          if (in_valid) begin
            q_res <= c_res;
            q_we  <= c_we;
            q_dst <= dest;
          end
        end
      end

      assign out_valid = q_valid;
      assign result    = q_res;
      assign wr_en     = q_we;
      assign wr_dest   = q_dst;
    end else begin : g_pass
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign result    = c_res;
      assign wr_en     = c_we;
      assign wr_dest   = dest;
    end
  endgenerate
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk
  import alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 5,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [OP_W-1:0]   op,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] result,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_dest
);
  a_r11_no_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && wr_en |-> wr_dest != '0);

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(result) && $stable(wr_en) && $stable(wr_dest));

  generate
    if (REG_OUT) begin : g_reg
      a_r12_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

      a_r12_issue_next: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

      a_r5_cmp_bool: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && op_is_cmp(op) |=> result[DATA_W-1:1] == '0);
    end else begin : g_comb
      a_r5_cmp_bool: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && op_is_cmp(op) |-> result[DATA_W-1:1] == '0);
    end
  endgenerate
endmodule

bind int_alu int_alu_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .op(op),
  .out_valid(out_valid), .out_ready(out_ready), .result(result),
  .wr_en(wr_en), .wr_dest(wr_dest)
);

// File: tb/int_alu_tb.sv
`timescale 1ns/1ps
module int_alu_tb;
  import alu_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, out_ready = 1'b1;
  logic [5:0]  op = '0;
  logic [4:0]  src_a = '0, src_b = '0, dest = '0, shamt = '0;
  logic [31:0] opa = '0, opb = '0;
  logic [15:0] imm = '0;
  logic        in_ready, out_valid, wr_en;
  logic [31:0] result;
  logic [4:0]  wr_dest;

  int n_vec = 0, n_bad = 0;
  bit stall_mode = 1'b0;
  int cyc = 0;

  logic [31:0] q_res[$];
  logic        q_we[$];
  logic [4:0]  q_dst[$];
  string       q_tag[$];

  always #2 clk = ~clk;

  int_alu u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .op(op),
    .src_a(src_a), .opa(opa), .src_b(src_b), .opb(opb), .imm(imm), .shamt(shamt),
    .dest(dest), .out_valid(out_valid), .out_ready(out_ready), .result(result),
    .wr_en(wr_en), .wr_dest(wr_dest)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rotl(logic [31:0] v, int n);
    return (n == 0) ? v : ((v << n) | (v >> (32 - n)));
  endfunction

  function automatic logic [31:0] rotr(logic [31:0] v, int n);
    return (n == 0) ? v : ((v >> n) | (v << (32 - n)));
  endfunction

  function automatic string tag_of(logic [5:0] c);
    if (c <= 6) return "R1";
    if (c <= 8) return "R2";
    if (c <= 11) return "R3";
    if (c <= 14) return "R4";
    if (c <= 20) return "R5";
    if (c <= 26) return "R6";
    if (c <= 31) return "R7";
    if (c <= 35) return "R8";
    if (c <= 38) return "R9";
    return "R11";
  endfunction

  // behavioural reference of one operation
  function automatic void model(input logic [5:0] c, input logic [31:0] a, input logic [31:0] b,
                                input logic [15:0] im, input logic [4:0] sh,
                                output logic [31:0] r, output bit ok);
    logic [31:0] se, ze, hi;
    longint sp;
    logic [63:0] up;
    se = {{16{im[15]}}, im};
    ze = {16'h0, im};
    hi = {im, 16'h0};
    ok = 1'b1;
    r = '0;
    case (alu_op_e'(c))
      OP_ADD:    r = a + b;
      OP_SUB:    r = a - b;
      OP_MUL:    r = a * b;
      OP_AND:    r = a & b;
      OP_OR:     r = a | b;
      OP_XOR:    r = a ^ b;
      OP_NOR:    r = ~(a | b);
      OP_ADDI:   r = a + se;
      OP_MULI:   r = a * se;
      OP_ANDI:   r = a & ze;
      OP_ORI:    r = a | ze;
      OP_XORI:   r = a ^ ze;
      OP_ANDHI:  r = a & hi;
      OP_ORHI:   r = a | hi;
      OP_XORHI:  r = a ^ hi;
      OP_CGE:    r = 32'($signed(a) >= $signed(b));
      OP_CLT:    r = 32'($signed(a) < $signed(b));
      OP_CNE:    r = 32'(a != b);
      OP_CEQ:    r = 32'(a == b);
      OP_CGEU:   r = 32'(a >= b);
      OP_CLTU:   r = 32'(a < b);
      OP_CGEI:   r = 32'($signed(a) >= $signed(se));
      OP_CLTI:   r = 32'($signed(a) < $signed(se));
      OP_CNEI:   r = 32'(a != se);
      OP_CEQI:   r = 32'(a == se);
      OP_CGEUI:  r = 32'(a >= ze);
      OP_CLTUI:  r = 32'(a < ze);
      OP_SRA:    r = 32'($signed(a) >>> b[4:0]);
      OP_SRL:    r = a >> b[4:0];
      OP_SLL:    r = a << b[4:0];
      OP_ROL:    r = rotl(a, int'(b[4:0]));
      OP_ROR:    r = rotr(a, int'(b[4:0]));
      OP_SRAI:   r = 32'($signed(a) >>> sh);
      OP_SRLI:   r = a >> sh;
      OP_SLLI:   r = a << sh;
      OP_ROLI:   r = rotl(a, int'(sh));
      OP_MULHSS: begin sp = longint'($signed(a)) * longint'($signed(b)); r = sp[63:32]; end
      OP_MULHUU: begin up = {32'h0, a} * {32'h0, b}; r = up[63:32]; end
      OP_MULHSU: begin sp = longint'($signed(a)) * longint'({32'h0, b}); r = sp[63:32]; end
      default:   ok = 1'b0;
    endcase
  endfunction

  // consumer pacing
  always begin
    @(negedge clk);
    #0.5;
    cyc++;
    out_ready = stall_mode ? (cyc % 3 == 0) : 1'b1;
  end

  // monitor: samples shortly before each rising edge
  bit          prev_stall = 1'b0;
  logic [31:0] prev_res;
  logic        prev_we;
  logic [4:0]  prev_dst;
  always begin
    @(negedge clk);
    #1.5;
    if (rst_n) begin
      if (prev_stall) begin
        chk(out_valid === 1'b1, "R12", "valid held", 32'(out_valid), 32'h1);
        chk(result === prev_res && wr_en === prev_we && wr_dest === prev_dst,
            "R12", "payload held", result, prev_res);
      end
      if (in_valid && in_ready) begin
        logic [31:0] r, av, bv;
        bit ok;
        av = (src_a == 0) ? 32'h0 : opa;
        bv = (src_b == 0) ? 32'h0 : opb;
        model(op, av, bv, imm, shamt, r, ok);
        q_res.push_back(r);
        q_we.push_back(ok && dest != 0);
        q_dst.push_back(dest);
        q_tag.push_back(tag_of(op));
      end
      if (out_valid && out_ready) begin
        if (q_res.size() == 0) begin
          chk(1'b0, "R12", "unexpected result", result, 32'h0);
        end else begin
          logic [31:0] er;
          logic        ew;
          logic [4:0]  ed;
          string       et;
          er = q_res.pop_front();
          ew = q_we.pop_front();
          ed = q_dst.pop_front();
          et = q_tag.pop_front();
          chk(result === er, et, "result", result, er);
          chk(wr_en === ew, "R11", "wr_en", 32'(wr_en), 32'(ew));
          if (ew) chk(wr_dest === ed, "R11", "wr_dest", 32'(wr_dest), 32'(ed));
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_res = result;
      prev_we = wr_en;
      prev_dst = wr_dest;
    end
  end

  task automatic issue(input alu_op_e o, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input logic [4:0] sh,
                       input logic [4:0] sa = 5'd1, input logic [4:0] sb = 5'd2,
                       input logic [4:0] d = 5'd3);
    issue_raw(6'(o), a, b, im, sh, sa, sb, d);
  endtask

  task automatic issue_raw(input logic [5:0] o, input logic [31:0] a, input logic [31:0] b,
                           input logic [15:0] im, input logic [4:0] sh,
                           input logic [4:0] sa, input logic [4:0] sb, input logic [4:0] d);
    @(negedge clk);
    #0.5;
    op = o; opa = a; opb = b; imm = im; shamt = sh;
    src_a = sa; src_b = sb; dest = d;
    in_valid = 1'b1;
    #1.0;
    while (!in_ready) begin
      @(negedge clk);
      #1.5;
    end
    @(posedge clk);
    #0.1;
    in_valid = 1'b0;
  endtask

  initial begin
    #(4.0 * 150000);
    n_bad++;
    $display("FAIL watchdog R12: actual stalled expected progress");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1.5;
    chk(out_valid === 1'b0, "R13", "valid in reset", 32'(out_valid), 32'h0);
    @(negedge clk);
    #0.5;
    rst_n = 1'b1;
    @(negedge clk);
    #1.5;
    chk(out_valid === 1'b0, "R13", "valid after reset", 32'(out_valid), 32'h0);
    chk(in_ready === 1'b1, "R12", "ready when empty", 32'(in_ready), 32'h1);

    // R1 register forms
    issue(OP_ADD, 32'hFFFF_FFFF, 32'h1, 0, 0);
    issue(OP_SUB, 32'd5, 32'd7, 0, 0);
    issue(OP_MUL, 32'h0001_0000, 32'h0001_0003, 0, 0);
    issue(OP_AND, 32'hF0F0_1234, 32'h0FF0_FF00, 0, 0);
    issue(OP_OR,  32'hF000_0001, 32'h0000_8000, 0, 0);
    issue(OP_XOR, 32'hAAAA_5555, 32'hFFFF_0000, 0, 0);
    issue(OP_NOR, 32'h0000_FFFF, 32'h00FF_0000, 0, 0);
    // R2 sign-extended immediates
    issue(OP_ADDI, 32'd100, 0, 16'hFFFF, 0);
    issue(OP_MULI, 32'd3, 0, 16'h8000, 0);
    // R3 zero-extended immediates
    issue(OP_ANDI, 32'hFFFF_FFFF, 0, 16'h8001, 0);
    issue(OP_ORI,  32'h1200_0000, 0, 16'h8000, 0);
    issue(OP_XORI, 32'hFFFF_FFFF, 0, 16'hFFFF, 0);
    // R4 upper-half immediates
    issue(OP_ANDHI, 32'h1234_5678, 0, 16'hFF00, 0);
    issue(OP_ORHI,  32'h0000_00FF, 0, 16'h8001, 0);
    issue(OP_XORHI, 32'hFFFF_FFFF, 0, 16'h00FF, 0);
    // R5 register compares
    issue(OP_CGE,  32'hFFFF_FFFF, 32'h1, 0, 0);
    issue(OP_CLT,  32'hFFFF_FFFF, 32'h1, 0, 0);
    issue(OP_CGEU, 32'hFFFF_FFFF, 32'h1, 0, 0);
    issue(OP_CLTU, 32'hFFFF_FFFF, 32'h1, 0, 0);
    issue(OP_CNE,  32'h7, 32'h7, 0, 0);
    issue(OP_CEQ,  32'h7, 32'h7, 0, 0);
    issue(OP_CGE,  32'h8000_0000, 32'h8000_0000, 0, 0);
    // R6 immediate compares
    issue(OP_CEQI,  32'hFFFF_FFFF, 0, 16'hFFFF, 0);
    issue(OP_CNEI,  32'h0000_FFFF, 0, 16'hFFFF, 0);
    issue(OP_CLTI,  32'hFFFF_FFFE, 0, 16'hFFFF, 0);
    issue(OP_CGEI,  32'h0, 0, 16'h8000, 0);
    issue(OP_CGEUI, 32'h0000_FFFF, 0, 16'hFFFF, 0);
    issue(OP_CLTUI, 32'h0001_0000, 0, 16'hFFFF, 0);
    // R7 register amount masked to 5 bits
    issue(OP_SLL, 32'h1, 32'hFFFF_FFE1, 0, 0);
    issue(OP_SRA, 32'h8000_0000, 32'h24, 0, 0);
    issue(OP_SRL, 32'h8000_0000, 32'h3F, 0, 0);
    issue(OP_ROL, 32'h8765_4321, 32'h20, 0, 0);
    issue(OP_ROR, 32'h8765_4321, 32'h108, 0, 0);
    // R8 immediate amounts
    issue(OP_SLLI, 32'h1234_5678, 0, 0, 5'd0);
    issue(OP_SRLI, 32'h8000_0000, 0, 0, 5'd31);
    issue(OP_SRAI, 32'h8000_0000, 0, 0, 5'd31);
    issue(OP_ROLI, 32'h8000_0001, 0, 0, 5'd31);
    issue(OP_ROLI, 32'hDEAD_BEEF, 0, 0, 5'd0);
    // R9 multiply-high
    issue(OP_MULHSS, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0);
    issue(OP_MULHUU, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0);
    issue(OP_MULHSU, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0);
    issue(OP_MULHSS, 32'h8000_0000, 32'h8000_0000, 0, 0);
    // R10 index 0 reads zero
    issue(OP_ADD, 32'h5555_5555, 32'h11, 0, 0, 5'd0, 5'd2, 5'd4);
    issue(OP_OR,  32'h22, 32'hAAAA_AAAA, 0, 0, 5'd1, 5'd0, 5'd4);
    // R11 no write to register 0, undefined codes
    issue(OP_ADD, 32'h1, 32'h2, 0, 0, 5'd1, 5'd2, 5'd0);
    issue_raw(6'd45, 32'h1, 32'h2, 16'h3, 5'd1, 5'd1, 5'd2, 5'd7);
    issue_raw(6'd63, 32'hFFFF_FFFF, 32'h2, 16'h3, 5'd1, 5'd1, 5'd2, 5'd7);

    // random mix, free-flowing then with back-pressure (R12)
    for (int pass = 0; pass < 2; pass++) begin
      stall_mode = (pass == 1);
      for (int i = 0; i < 300; i++) begin
        issue_raw(6'($urandom_range(0, 40)), $urandom, $urandom, 16'($urandom), 5'($urandom),
                  5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)), 5'($urandom_range(0, 31)));
      end
    end
    stall_mode = 1'b0;
    repeat (10) @(negedge clk);
    chk(q_res.size() == 0, "R12", "all results delivered", 32'(q_res.size()), 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule